// File: doc/BRIEF.md
# Dominant Harmonic Order Selector

This block sits behind a radix-2 spectrum engine that analyses the voltage at the point where an inverter meets its loads. One analysis frame arrives as a stream of magnitude values, each tagged with its bin number. The stream is bracketed by a frame-start strobe and a frame-end strobe. The frame length is a power of two. A frame with fewer real samples is zero-padded upstream, so bins that are never sent or that carry zero act the same way.

While a frame streams in, the block looks only at bins that lie on integer multiples of the fundamental bin, from the second harmonic up to a maximum order set by a parameter. It keeps the two largest of these, ranked by magnitude. The fundamental, the DC bin and every bin between harmonics are ignored. When the frame ends, the block publishes the two winning harmonic orders. It also publishes an enable mask for a bank of resonant-controller coefficient sets that were prepared in advance, one set per order. The fundamental set is always enabled, and the sets of the two selected orders are added to it. The selection is redone for every frame, so the chosen orders follow the spectrum as compensation changes it.

Top module: `harm_order_select`

## Requirements
- R1: After reset, both order outputs are 0, the done pulse is low, and the enable mask has only bit 1 set (the fundamental).
- R2: When published, order0 holds the harmonic order with the largest magnitude and order1 holds the order with the second largest magnitude.
- R3: A bin is a candidate only if its index equals h × FUND_BIN for an integer h with 2 ≤ h ≤ MAX_ORDER and h × FUND_BIN < FRAME_LEN/2. DC, the fundamental, bins between harmonics and orders above MAX_ORDER never affect the result.
- R4: When two candidates have equal magnitude, the lower harmonic order ranks higher, whatever order the bins arrive in.
- R5: A candidate with zero magnitude is never selected. An order output whose slot found no non-zero candidate reads 0.
- R6: Bit n of the enable mask enables the coefficient set of harmonic order n. Bit 1 is always set, the bit of each non-zero published order is set, and every other bit is clear.
- R7: done is high for exactly the one cycle after a cycle with frame_end high. order0, order1 and the mask change only in that cycle and hold their values otherwise.
- R8: frame_start discards every candidate gathered before it. A sample presented in the same cycle as frame_start belongs to the new frame. Each frame is ranked on its own.
- R9: A sample presented in the same cycle as frame_end is included in the result published for that frame.
- R10: Cycles with mag_valid low have no effect on the ranking, whatever the bin and magnitude inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Begins a new analysis frame |
| frame_end | input | 1 | Ends the frame and requests publication |
| mag_valid | input | 1 | Qualifies mag_bin and mag_value |
| mag_bin | input | $clog2(FRAME_LEN) | Spectrum bin index of the sample |
| mag_value | input | MAG_W | Magnitude of the bin |
| order0 | output | ORD_W | Harmonic order with the largest magnitude, 0 if none |
| order1 | output | ORD_W | Harmonic order with the second largest magnitude, 0 if none |
| coef_en | output | MAX_ORDER+1 | Coefficient-set enable mask, bit n for order n |
| done | output | 1 | One-cycle pulse when new results are published |

## Verification
The bench builds the block with FRAME_LEN = 64, FUND_BIN = 2 and MAX_ORDER = 7. This keeps the candidate set small enough to list by hand and still gives odd bins that fall between harmonics. With these values, bin 16 is the 8th harmonic and lies just above the order limit, so the cut-off at MAX_ORDER can be shown to reject a large magnitude. The 8-bit enable mask can be compared whole against a value computed by hand. Frames repeat with different dominant orders, include samples on the start and end strobes, and include ties and zero-magnitude bins.

// File: rtl/harm_sel_pkg.sv
package harm_sel_pkg;

    localparam int unsigned MAG_W = 16;
    localparam int unsigned ORD_W = 5;

    typedef struct packed {
        logic             vld;
        logic [ORD_W-1:0] ord;
        logic [MAG_W-1:0] mag;
    } slot_t;

    typedef struct packed {
        slot_t first;
        slot_t second;
    } top2_t;

    localparam slot_t SLOT_EMPTY = '{vld: 1'b0, ord: '0, mag: '0};
    localparam top2_t TOP2_EMPTY = '{first: SLOT_EMPTY, second: SLOT_EMPTY};

    // a outranks b: larger magnitude, lower order on equal magnitude
    function automatic logic slot_beats(input slot_t a, input slot_t b);
        if (!a.vld)
            return 1'b0;
        if (!b.vld)
            return 1'b1;
        if (a.mag != b.mag)
            return a.mag > b.mag;
        return a.ord < b.ord;
    endfunction

    function automatic top2_t top2_insert(input top2_t base, input slot_t cand);
        top2_t r;
        r = base;
        if (slot_beats(cand, base.first)) begin
            r.second = base.first;
            r.first  = cand;
        end else if (slot_beats(cand, base.second)) begin
            r.second = cand;
        end
        return r;
    endfunction

endpackage

// File: rtl/harm_bin_decode.sv
module harm_bin_decode
    import harm_sel_pkg::*;
#(
    parameter int unsigned BIN_W     = 8,
    parameter int unsigned FUND_BIN  = 4,
    parameter int unsigned MAX_ORDER = 15,
    parameter int unsigned HALF_BINS = 128
) (
    input  logic [BIN_W-1:0] bin,
    output logic             hit,
    output logic [ORD_W-1:0] ord
);

    logic [MAX_ORDER:0] match;

    assign match[0] = 1'b0;
    assign match[1] = 1'b0;

    for (genvar h = 2; h <= MAX_ORDER; h++) begin : g_harm
        localparam int unsigned BIDX = h * FUND_BIN;
        if (BIDX < HALF_BINS) begin : g_in
            assign match[h] = (bin == BIDX[BIN_W-1:0]);
        end else begin : g_out
            assign match[h] = 1'b0;
        end
    end

    always_comb begin
        ord = '0;
        for (int h = 2; h <= int'(MAX_ORDER); h++) begin
            if (match[h])
                ord = ord | ORD_W'(h);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/harm_top2_rank.sv
module harm_top2_rank
    import harm_sel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  slot_t cand,
    output top2_t nxt
);

    top2_t cur;
    top2_t base;

    always_comb begin
        base = clear ? TOP2_EMPTY : cur;
        nxt  = top2_insert(base, cand);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= TOP2_EMPTY;
        else
            cur <= nxt;
    end

endmodule

// File: rtl/harm_sel_out.sv
module harm_sel_out
    import harm_sel_pkg::*;
#(
    parameter int unsigned MAX_ORDER = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               publish,
    input  top2_t              res,
    output logic [ORD_W-1:0]   order0,
    output logic [ORD_W-1:0]   order1,
    output logic [MAX_ORDER:0] coef_en,
    output logic               done
);

    localparam logic [MAX_ORDER:0] FUND_MASK = (MAX_ORDER+1)'(2);

    logic [MAX_ORDER:0] en_nxt;

    always_comb begin
        en_nxt = FUND_MASK;
        if (res.first.vld)
            en_nxt[res.first.ord] = 1'b1;
        if (res.second.vld)
            en_nxt[res.second.ord] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            order0  <= '0;
            order1  <= '0;
            coef_en <= FUND_MASK;
            done    <= 1'b0;
        end else begin
            done <= publish;
            if (publish) begin
                order0  <= res.first.vld  ? res.first.ord  : '0;
                order1  <= res.second.vld ? res.second.ord : '0;
                coef_en <= en_nxt;
            end
        end
    end

endmodule

// File: rtl/harm_order_select.sv
module harm_order_select
    import harm_sel_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 256,
    parameter int unsigned FUND_BIN  = 4,
    parameter int unsigned MAX_ORDER = 15,
    parameter int unsigned BIN_W     = $clog2(FRAME_LEN)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_start,
    input  logic                     frame_end,
    input  logic                     mag_valid,
    input  logic [BIN_W-1:0]         mag_bin,
    input  logic [MAG_W-1:0]         mag_value,
    output logic [ORD_W-1:0]         order0,
    output logic [ORD_W-1:0]         order1,
    output logic [MAX_ORDER:0]       coef_en,
    output logic                     done
);

    localparam int unsigned HALF_BINS = FRAME_LEN / 2;

    logic             hit;
    logic [ORD_W-1:0] hit_ord;
    slot_t            cand;
    top2_t            ranked;

    harm_bin_decode #(
        .BIN_W    (BIN_W),
        .FUND_BIN (FUND_BIN),
        .MAX_ORDER(MAX_ORDER),
        .HALF_BINS(HALF_BINS)
    ) u_dec (
        .bin(mag_bin),
        .hit(hit),
        .ord(hit_ord)
    );

    always_comb begin
        cand.vld = mag_valid && hit && (mag_value != '0);
        cand.ord = hit_ord;
        cand.mag = mag_value;
    end

    harm_top2_rank u_rank (
        .clk  (clk),
        .rst  (rst),
        .clear(frame_start),
        .cand (cand),
        .nxt  (ranked)
    );

    harm_sel_out #(
        .MAX_ORDER(MAX_ORDER)
    ) u_out (
        .clk    (clk),
        .rst    (rst),
        .publish(frame_end),
        .res    (ranked),
        .order0 (order0),
        .order1 (order1),
        .coef_en(coef_en),
        .done   (done)
    );

endmodule

// File: rtl/harm_order_select_chk.sv
module harm_order_select_chk
    import harm_sel_pkg::*;
#(
    parameter int unsigned MAX_ORDER = 15
) (
    input logic               clk,
    input logic               rst,
    input logic               frame_end,
    input logic [ORD_W-1:0]   order0,
    input logic [ORD_W-1:0]   order1,
    input logic [MAX_ORDER:0] coef_en,
    input logic               done
);

    AST_FUND_ALWAYS_ON: assert property (@(posedge clk) disable iff (rst)
        coef_en[1]); // R6

    AST_MASK_AT_MOST_THREE: assert property (@(posedge clk) disable iff (rst)
        $countones(coef_en) <= 3); // R6

    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(frame_end)); // R7

    AST_HOLD_BETWEEN_DONE: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(order0) && $stable(order1) && $stable(coef_en))); // R7

    AST_ORDERS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (order0 != '0) |-> (order0 != order1)); // R2

    AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (rst)
        (order1 != '0) |-> (order0 != '0)); // R5

    AST_ORDER_RANGE: assert property (@(posedge clk) disable iff (rst)
        (order0 == '0) || ((order0 >= 2) && (order0 <= ORD_W'(MAX_ORDER)))); // R3

    AST_SELECTED_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (order0 != '0) |-> coef_en[order0]); // R6

endmodule

bind harm_order_select harm_order_select_chk #(
    .MAX_ORDER(MAX_ORDER)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .frame_end(frame_end),
    .order0   (order0),
    .order1   (order1),
    .coef_en  (coef_en),
    .done     (done)
);

// File: tb/harm_order_select_tb.sv
module harm_order_select_tb;
    import harm_sel_pkg::*;

    localparam int unsigned FRAME_LEN = 64;
    localparam int unsigned FUND_BIN  = 2;
    localparam int unsigned MAX_ORDER = 7;
    localparam int unsigned BIN_W     = $clog2(FRAME_LEN);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               frame_start = 1'b0;
    logic               frame_end = 1'b0;
    logic               mag_valid = 1'b0;
    logic [BIN_W-1:0]   mag_bin = '0;
    logic [MAG_W-1:0]   mag_value = '0;
    logic [ORD_W-1:0]   order0;
    logic [ORD_W-1:0]   order1;
    logic [MAX_ORDER:0] coef_en;
    logic               done;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    harm_order_select #(
        .FRAME_LEN(FRAME_LEN),
        .FUND_BIN (FUND_BIN),
        .MAX_ORDER(MAX_ORDER)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .mag_valid  (mag_valid),
        .mag_bin    (mag_bin),
        .mag_value  (mag_value),
        .order0     (order0),
        .order1     (order1),
        .coef_en    (coef_en),
        .done       (done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        frame_start = 1'b0; frame_end = 1'b0; mag_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_frame();
        frame_start = 1'b1; mag_valid = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic send(input int b, input int m);
        mag_valid = 1'b1; mag_bin = BIN_W'(b); mag_value = MAG_W'(m);
        @(negedge clk);
        mag_valid = 1'b0;
    endtask

    // frame_end for one cycle; returns at the negedge where done should be high
    task automatic end_frame();
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        mag_valid = 1'b0;
    endtask

    task automatic check_result(input string tag, input int o0, input int o1, input int en);
        chk({tag, " R7 done"}, int'(done), 1);
        chk({tag, " R2 order0"}, int'(order0), o0);
        chk({tag, " R2 order1"}, int'(order1), o1);
        chk({tag, " R6 coef_en"}, int'(coef_en), en);
        @(negedge clk);
        chk({tag, " R7 done drop"}, int'(done), 0);
    endtask

    task automatic t_reset();
        chk("R1 order0", int'(order0), 0);
        chk("R1 order1", int'(order1), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 coef_en", int'(coef_en), 'h02);
    endtask

    task automatic t_basic();
        start_frame();
        send(10, 500);  // order 5
        send(14, 300);  // order 7
        send(6, 100);   // order 3
        end_frame();
        check_result("basic", 5, 7, 'hA2);
    endtask

    task automatic t_ignore();
        start_frame();
        send(0, 9999);   // DC
        send(2, 9999);   // fundamental
        send(7, 9000);   // between harmonics
        send(16, 9000);  // order 8 > MAX_ORDER
        send(6, 50);     // order 3
        send(4, 40);     // order 2
        mag_bin = 6'd10; mag_value = 16'd8000; mag_valid = 1'b0; // R10
        @(negedge clk);
        end_frame();
        check_result("ignore R3 R10", 3, 2, 'h0E);
    endtask

    task automatic t_tie();
        start_frame();
        send(14, 200);  // order 7
        send(12, 200);  // order 6
        send(8, 200);   // order 4
        end_frame();
        check_result("tie R4", 4, 6, 'h52);
    endtask

    task automatic t_zero();
        start_frame();
        send(6, 0);     // order 3, zero
        send(10, 77);   // order 5
        send(4, 0);     // order 2, zero
        end_frame();
        check_result("zero R5", 5, 0, 'h22);
        start_frame();
        end_frame();
        check_result("empty R5", 0, 0, 'h02);
    endtask

    task automatic t_refresh();
        start_frame();
        send(10, 600); send(14, 500); send(6, 100);
        end_frame();
        check_result("refresh f1 R8", 5, 7, 'hA2);
        // new frame after discarding old candidates; outputs must hold meanwhile
        start_frame();
        send(14, 400); send(6, 200); send(10, 50);
        chk("R7 hold order0", int'(order0), 5);
        chk("R7 hold order1", int'(order1), 7);
        chk("R7 hold coef_en", int'(coef_en), 'hA2);
        end_frame();
        check_result("refresh f2 R8", 7, 3, 'h8A);
    endtask

    task automatic t_edges();
        start_frame();
        send(12, 3000); send(14, 2500);
        // frame_start together with a sample: old candidates dropped, sample kept
        frame_start = 1'b1; mag_valid = 1'b1; mag_bin = 6'd8; mag_value = 16'd30;
        @(negedge clk);
        frame_start = 1'b0; mag_valid = 1'b0;
        send(4, 10);
        // sample on the frame_end cycle is included
        mag_valid = 1'b1; mag_bin = 6'd12; mag_value = 16'd900;
        end_frame();
        check_result("edges R8 R9", 6, 4, 'h52);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        idle();
        t_reset();
        t_basic();
        t_ignore();
        t_tie();
        t_zero();
        t_refresh();
        t_edges();
        idle();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule